// File: doc/BRIEF.md
# Rectangle Fill Drawing Engine

This block takes drawing work off a host processor. The host writes a small set of 16-bit registers: two opposite corners of a rectangle, a colour and a command code. Writing the command register starts a job. The engine then visits the requested pixels one at a time. For each pixel it offers one word write, an address and a colour, on a valid/ready memory stream. The host polls a read-only busy bit to learn when the job is done.

Three commands exist. Command 0 paints the whole screen. Command 2 paints a solid rectangle. Command 1 paints only the outline of a rectangle. The pixel address is the row times 640 plus the column, built from two shifts and an add. The screen size that command 0 covers is set by parameters, 640 by 480 by default. The row stride of 640 is fixed and does not change with those parameters.

The memory stream follows valid/ready rules. While `mem_valid` is high and `mem_ready` is low, the engine holds its address and data. A write is taken on every rising edge where both are high. The engine moves to the next pixel only after that edge. The memory side may hold `mem_ready` low for as long as it needs, and no write is lost or repeated. The register interface is plain: a write takes effect on the clock edge where `reg_wr_valid` is high. Read data is a combinational function of `reg_rd_addr`.

Top module: `rect_fill_engine`

## Requirements
- R1: After reset every stored register reads zero, the busy bit is 0 and `mem_valid` is low.
- R2: Byte offsets 0x0, 0x2, 0x4, 0x6 and 0x8 hold the left column, top row, right column, bottom row and colour. Each reads back the full 16 bits last written. Offset 0xA is the command register and reads as zero. Offset 0xC is status: bit 0 is busy and bits 15:1 read zero. Every other offset reads zero.
- R3: A command register write taken while idle, with code 0, 1 or 2, makes busy and `mem_valid` high from the next cycle. The first write goes to the job's top-left pixel.
- R4: Each write carries address row*640 + column, using the low 10 bits of the coordinates, on a 20-bit `mem_addr`. Its data is the colour register value at the moment the command was written.
- R5: Command 2 writes every pixel from left to right, column by column. After the right column it returns to the left column on the next row. It ends after the bottom-right pixel.
- R6: Command 1 writes, in the same raster order, only the pixels on the left or right column or on the top or bottom row. Interior pixels get no write.
- R7: Command 0 writes columns 0 to SCREEN_W-1 and rows 0 to SCREEN_H-1 in raster order, whatever the coordinate registers hold.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_addr` and `mem_data` stay unchanged. The job advances exactly one pixel per accepted write.
- R9: Busy and `mem_valid` go low in the cycle after the last write is accepted.
- R10: A command write while busy is ignored. Coordinate and colour writes while busy are stored but do not change the running job.
- R11: A command write with any code other than 0, 1 or 2 causes no memory write, and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_valid | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register write byte offset |
| reg_wr_data | input | 16 | Register write data |
| reg_rd_addr | input | 4 | Register read byte offset |
| reg_rd_data | output | 16 | Register read data (combinational) |
| mem_valid | output | 1 | Pixel write offered |
| mem_ready | input | 1 | Memory accepts the offered write |
| mem_addr | output | 20 | Pixel word address |
| mem_data | output | 16 | Pixel colour |

## Verification
Solid boxes are driven with `mem_ready` always high and with `mem_ready` toggling every cycle. This separates a correct raster walk from one that skips or repeats pixels under back-pressure. Outline boxes are run with long stalls, including one-column and one-row shapes, to show that interior pixels are skipped and that the row-end wrap still works. A clear is issued with unrelated corners loaded, to show that the register contents are ignored. A box near column 1023 and row 1000 exercises the top bits of the address. Command writes during a job, colour changes during a job and an unknown code show that the running job cannot be disturbed and that a bad code starts nothing.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  localparam int COORD_W  = 10;
  localparam int WORD_W   = 16;
  localparam int OFF_W    = 4;
  localparam int STRIDE_SH_HI = 9;
  localparam int STRIDE_SH_LO = 7;

  localparam logic [OFF_W-1:0] OFF_LEFT   = 4'h0;
  localparam logic [OFF_W-1:0] OFF_TOP    = 4'h2;
  localparam logic [OFF_W-1:0] OFF_RIGHT  = 4'h4;
  localparam logic [OFF_W-1:0] OFF_BOTTOM = 4'h6;
  localparam logic [OFF_W-1:0] OFF_COLOUR = 4'h8;
  localparam logic [OFF_W-1:0] OFF_CMD    = 4'hA;
  localparam logic [OFF_W-1:0] OFF_STATUS = 4'hC;

  localparam logic [WORD_W-1:0] CODE_CLEAR   = 16'd0;
  localparam logic [WORD_W-1:0] CODE_OUTLINE = 16'd1;
  localparam logic [WORD_W-1:0] CODE_SOLID   = 16'd2;

  typedef logic [COORD_W-1:0] coord_t;
  typedef logic [WORD_W-1:0]  word_t;

  typedef enum logic [0:0] { WALK_SOLID = 1'b0, WALK_OUTLINE = 1'b1 } walk_e;

  typedef struct packed {
    coord_t x_lo;
    coord_t y_lo;
    coord_t x_hi;
    coord_t y_hi;
    word_t  colour;
    walk_e  walk;
  } job_t;
endpackage

// File: rtl/rfe_regs.sv
module rfe_regs
  import rfe_pkg::*;
#(
  parameter int SCREEN_W = 640,
  parameter int SCREEN_H = 480
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [OFF_W-1:0] wr_addr,
  input  word_t            wr_data,
  input  logic [OFF_W-1:0] rd_addr,
  output word_t            rd_data,
  input  logic             busy,
  output logic             start,
  output job_t             job
);
  localparam coord_t LAST_COL = COORD_W'(SCREEN_W - 1);
  localparam coord_t LAST_ROW = COORD_W'(SCREEN_H - 1);

  word_t left_q, top_q, right_q, bottom_q, colour_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q   <= '0;
      top_q    <= '0;
      right_q  <= '0;
      bottom_q <= '0;
      colour_q <= '0;
    end else if (wr_valid) begin
      case (wr_addr)
        OFF_LEFT:   left_q   <= wr_data;
        OFF_TOP:    top_q    <= wr_data;
        OFF_RIGHT:  right_q  <= wr_data;
        OFF_BOTTOM: bottom_q <= wr_data;
        OFF_COLOUR: colour_q <= wr_data;
        default: ;
      endcase
    end
  end

  logic code_known;
  assign code_known = (wr_data == CODE_CLEAR) || (wr_data == CODE_OUTLINE) ||
                      (wr_data == CODE_SOLID);
  assign start = wr_valid && (wr_addr == OFF_CMD) && !busy && code_known;

  always_comb begin
    job.colour = colour_q;
    if (wr_data == CODE_CLEAR) begin
      job.x_lo = '0;
      job.y_lo = '0;
      job.x_hi = LAST_COL;
      job.y_hi = LAST_ROW;
      job.walk = WALK_SOLID;
    end else begin
      job.x_lo = left_q[COORD_W-1:0];
      job.y_lo = top_q[COORD_W-1:0];
      job.x_hi = right_q[COORD_W-1:0];
      job.y_hi = bottom_q[COORD_W-1:0];
      job.walk = (wr_data == CODE_OUTLINE) ? WALK_OUTLINE : WALK_SOLID;
    end
  end

  always_comb begin
    case (rd_addr)
      OFF_LEFT:   rd_data = left_q;
      OFF_TOP:    rd_data = top_q;
      OFF_RIGHT:  rd_data = right_q;
      OFF_BOTTOM: rd_data = bottom_q;
      OFF_COLOUR: rd_data = colour_q;
      OFF_STATUS: rd_data = {{(WORD_W-1){1'b0}}, busy};
      default:    rd_data = '0;
    endcase
  end

  a_r10_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_valid && wr_addr == OFF_CMD) |-> !start);
endmodule

// File: rtl/rfe_addr.sv
module rfe_addr
  import rfe_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  coord_t            col,
  input  coord_t            row,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] row_w, col_w;
  assign row_w = ADDR_W'(row);
  assign col_w = ADDR_W'(col);
  assign addr  = (row_w << STRIDE_SH_HI) + (row_w << STRIDE_SH_LO) + col_w;
endmodule

// File: rtl/rfe_walker.sv
module rfe_walker
  import rfe_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  job_t   job,
  input  logic   step,
  output logic   busy,
  output coord_t col,
  output coord_t row,
  output word_t  colour
);
  job_t   cur_q;
  logic   busy_q;
  coord_t col_q, row_q;

  logic at_row_end, at_last, edge_row;
  assign at_row_end = (col_q == cur_q.x_hi);
  assign at_last    = at_row_end && (row_q == cur_q.y_hi);
  assign edge_row   = (row_q == cur_q.y_lo) || (row_q == cur_q.y_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      busy_q <= 1'b0;
      col_q  <= '0;
      row_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        cur_q  <= job;
        col_q  <= job.x_lo;
        row_q  <= job.y_lo;
        busy_q <= 1'b1;
      end
    end else if (step) begin
      if (at_row_end) begin
        if (at_last) begin
          busy_q <= 1'b0;
        end else begin
          col_q <= cur_q.x_lo;
          row_q <= row_q + 1'b1;
        end
      end else if (cur_q.walk == WALK_SOLID || edge_row) begin
        col_q <= col_q + 1'b1;
      end else begin
        col_q <= cur_q.x_hi;
      end
    end
  end

  assign busy   = busy_q;
  assign col    = col_q;
  assign row    = row_q;
  assign colour = cur_q.colour;

  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step) |=> (busy && $stable(col) && $stable(row) && $stable(colour)));

  a_r6_outline_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_q.walk == WALK_OUTLINE) |->
      (col == cur_q.x_lo || col == cur_q.x_hi || row == cur_q.y_lo || row == cur_q.y_hi));

  a_r5_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_q.x_lo <= cur_q.x_hi && cur_q.y_lo <= cur_q.y_hi) |->
      (col >= cur_q.x_lo && col <= cur_q.x_hi && row >= cur_q.y_lo && row <= cur_q.y_hi));

  a_r9_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step && at_last) |=> !busy);
endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
  import rfe_pkg::*;
#(
  parameter int SCREEN_W = 640,
  parameter int SCREEN_H = 480,
  parameter int ADDR_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_valid,
  input  logic [3:0]        reg_wr_addr,
  input  logic [15:0]       reg_wr_data,
  input  logic [3:0]        reg_rd_addr,
  output logic [15:0]       reg_rd_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_data
);
  logic   start, busy;
  job_t   job;
  coord_t col, row;
  word_t  colour;

  rfe_regs #(.SCREEN_W(SCREEN_W), .SCREEN_H(SCREEN_H)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(reg_wr_valid), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
    .busy(busy), .start(start), .job(job)
  );

  rfe_walker u_walker (
    .clk(clk), .rst_n(rst_n),
    .start(start), .job(job), .step(mem_ready),
    .busy(busy), .col(col), .row(row), .colour(colour)
  );

  rfe_addr #(.ADDR_W(ADDR_W)) u_addr (
    .col(col), .row(row), .addr(mem_addr)
  );

  assign mem_valid = busy;
  assign mem_data  = colour;

  a_r8_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));
endmodule

// File: tb/rect_fill_engine_bench.sv
`timescale 1ns/1ps
module rect_fill_engine_bench;
  localparam int SW = 12;
  localparam int SH = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_valid = 1'b0;
  logic [3:0]  reg_wr_addr = '0;
  logic [15:0] reg_wr_data = '0;
  logic [3:0]  reg_rd_addr = 4'hC;
  logic [15:0] reg_rd_data;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [19:0] mem_addr;
  logic [15:0] mem_data;

  rect_fill_engine #(.SCREEN_W(SW), .SCREEN_H(SH), .ADDR_W(20)) u_rect_fill_engine (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_valid(reg_wr_valid), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rmode = 0;
  int exp_addr[$];
  int exp_data[$];
  int m_left = 0, m_top = 0, m_right = 0, m_bottom = 0, m_colour = 0;

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic push_job(input int code);
    int l, t, r, b;
    l = m_left & 1023; t = m_top & 1023; r = m_right & 1023; b = m_bottom & 1023;
    if (code == 0) begin
      l = 0; t = 0; r = SW - 1; b = SH - 1;
    end
    if (code > 2) return;
    for (int y = t; y <= b; y++)
      for (int x = l; x <= r; x++)
        if (code != 1 || x == l || x == r || y == t || y == b) begin
          exp_addr.push_back(y * 640 + x);
          exp_data.push_back(m_colour);
        end
  endtask

  // One cycle: compare outputs against the model, then drive the next edge.
  task automatic tick(input bit we, input logic [3:0] wa, input logic [15:0] wd);
    bit busy_now, rdy;
    @(negedge clk);
    reg_rd_addr = 4'hC;
    #1;
    busy_now = exp_addr.size() > 0;
    chk("R2 R3 R9 status register", reg_rd_data, {15'b0, busy_now});
    chk("R3 R9 mem_valid", mem_valid, busy_now);
    if (busy_now && mem_valid) begin
      chk("R4 R5 R6 R7 address", mem_addr, exp_addr[0]);
      chk("R4 R10 data", mem_data, exp_data[0]);
    end
    cyc++;
    case (rmode)
      0: rdy = 1'b1;
      1: rdy = cyc[0];
      default: rdy = (cyc % 5) == 4;
    endcase
    mem_ready = rdy;
    if (rdy && busy_now) begin
      void'(exp_addr.pop_front());
      void'(exp_data.pop_front());
    end
    reg_wr_valid = we; reg_wr_addr = wa; reg_wr_data = wd;
    if (we) begin
      case (wa)
        4'h0: m_left = wd;
        4'h2: m_top = wd;
        4'h4: m_right = wd;
        4'h6: m_bottom = wd;
        4'h8: m_colour = wd;
        4'hA: if (!busy_now) push_job(wd);
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    tick(1'b1, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 4'h0, 16'h0);
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_addr.size() > 0 && guard < 5000) begin
      tick(1'b0, 4'h0, 16'h0);
      guard++;
    end
    idle(2);
    chk("R9 job finished", exp_addr.size(), 0);
  endtask

  task automatic peek(input logic [3:0] a, input int exp, input string what);
    reg_rd_addr = a;
    #1;
    chk(what, reg_rd_data, exp);
    reg_rd_addr = 4'hC;
  endtask

  task automatic setbox(input int l, input int t, input int r, input int b, input int c);
    wr(4'h0, 16'(l)); wr(4'h2, 16'(t)); wr(4'h4, 16'(r)); wr(4'h6, 16'(b)); wr(4'h8, 16'(c));
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #900000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    idle(1);
    peek(4'h0, 0, "R1 left after reset");
    peek(4'h2, 0, "R1 top after reset");
    peek(4'h4, 0, "R1 right after reset");
    peek(4'h6, 0, "R1 bottom after reset");
    peek(4'h8, 0, "R1 colour after reset");
    chk("R1 mem_valid after reset", mem_valid, 0);
    // R2: readback of the full 16 bits
    setbox(16'hFC03, 16'h8A02, 16'h7006, 16'h1204, 16'hBEEF);
    idle(1);
    peek(4'h0, 16'hFC03, "R2 left readback");
    peek(4'h2, 16'h8A02, "R2 top readback");
    peek(4'h4, 16'h7006, "R2 right readback");
    peek(4'h6, 16'h1204, "R2 bottom readback");
    peek(4'h8, 16'hBEEF, "R2 colour readback");
    peek(4'hA, 0, "R2 command reads zero");
    peek(4'hE, 0, "R2 unused offset reads zero");
    // R5: solid box, memory always ready (high coordinate bits ignored)
    rmode = 0;
    wr(4'hA, 16'd2);
    drain();
    // R8: solid box with alternating ready
    rmode = 1;
    setbox(3, 2, 6, 4, 16'h1234);
    wr(4'hA, 16'd2);
    drain();
    // R6: outline with long stalls, plus single column and single row shapes
    rmode = 2;
    setbox(10, 5, 15, 9, 16'h00F0);
    wr(4'hA, 16'd1);
    drain();
    setbox(7, 1, 7, 4, 16'h0F0F);
    wr(4'hA, 16'd1);
    drain();
    rmode = 1;
    setbox(2, 8, 9, 8, 16'h5555);
    wr(4'hA, 16'd1);
    drain();
    // R7: clear ignores the coordinate registers
    rmode = 0;
    setbox(100, 200, 101, 201, 16'hA5A5);
    wr(4'hA, 16'd0);
    drain();
    // R10: command and colour writes during a job
    rmode = 2;
    setbox(1, 1, 4, 3, 16'h0101);
    wr(4'hA, 16'd2);
    wr(4'h8, 16'h7777);
    wr(4'h0, 16'd50);
    wr(4'hA, 16'd0);
    wr(4'hA, 16'd1);
    drain();
    peek(4'h8, 16'h7777, "R10 colour stored while busy");
    peek(4'h0, 50, "R10 left stored while busy");
    // R11: unknown codes start nothing
    wr(4'hA, 16'd3);
    idle(4);
    wr(4'hA, 16'hFFFF);
    idle(4);
    chk("R11 no job after unknown code", mem_valid, 0);
    // R4: single pixel and high coordinates
    rmode = 0;
    setbox(1023, 1000, 1023, 1000, 16'hCAFE);
    wr(4'hA, 16'd2);
    drain();
    rmode = 1;
    setbox(1020, 1021, 1023, 1023, 16'h8001);
    wr(4'hA, 16'd1);
    drain();
    finish_run();
  end
endmodule